// File: doc/BRIEF.md
# SCSI Bus Phase Control Register

This block holds the 8-bit phase control register of a SCSI protocol core, together with the logic that checks the bus phase. A microcontroller writes and reads the register through a simple strobe port. When the core acts as a target, the register's phase bits and request bit drive the MSG, C/D, I/O and REQ line enables. When the core acts as an initiator, those enables stay off. The phase bits then serve as the expected phase: a mismatch seen on a rising REQ edge during DMA raises an interrupt, and an outgoing-data permit is given only while the live lines match.

The block also keeps a last-byte-sent flag. This flag is separate from the DMA side's end-of-transfer mark. It sets only when the byte that followed that mark has actually been handed to the bus. The live bus lines are asynchronous and pass through two flip-flops before any comparison.

Top module: `scsi_phase_ctl`

## Requirements
- R1: The register reads as {sent_flag, 3'b000, req_bit, msg_bit, cd_bit, io_bit}, with the flag in bit 7 and I/O in bit 0. Reset clears all bits, and bits 6..4 always read 0.
- R2: With `tgt_mode`=1, the outputs `drv_req`, `drv_msg`, `drv_cd` and `drv_io` equal register bits 3, 2, 1 and 0 from the clock edge that stores a write.
- R3: With `tgt_mode`=0, no line enable is asserted. This includes `drv_req`, whatever value register bit 3 holds.
- R4: Phases are encoded as {MSG,C/D,I/O}: 000 data out, 001 data in, 010 command, 011 status, 110 message out, 111 message in. `phase_irq` sets when all of the following hold: the synchronised REQ goes from 0 to 1, `tgt_mode`=0, `dma_mode`=1, and the synchronised live phase differs from register bits 2..0. The flag appears on the third rising edge after REQ rises at the pins.
- R5: `phase_irq` stays set until `int_clr` is pulsed. A REQ held high does not set it again after a clear.
- R6: `send_ok` is 1 only when `tgt_mode`=0 and the synchronised live phase equals register bits 2..0.
- R7: `undef_phase` is 1 while the synchronised live phase is 100 or 101.
- R8: With `tgt_mode`=0 and `dma_mode`=1, a `byte_sent` pulse that follows a `dma_last` pulse sets the last-byte flag (`last_sent`, register bit 7). A `byte_sent` with no earlier `dma_last` does not set it.
- R9: A register write or a `dma_start` pulse clears the last-byte flag. Writing 1 to bit 7 does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| tgt_mode | input | 1 | 1 = target role, 0 = initiator role |
| dma_mode | input | 1 | DMA transfer mode active |
| bus_req | input | 1 | Live REQ line (asserted high) |
| bus_msg | input | 1 | Live MSG line |
| bus_cd | input | 1 | Live C/D line |
| bus_io | input | 1 | Live I/O line |
| int_clr | input | 1 | Clears the phase-mismatch interrupt |
| dma_start | input | 1 | A new DMA transfer begins |
| dma_last | input | 1 | The DMA side has delivered its final byte |
| byte_sent | input | 1 | A byte was placed on the bus |
| drv_req | output | 1 | REQ line enable |
| drv_msg | output | 1 | MSG line enable |
| drv_cd | output | 1 | C/D line enable |
| drv_io | output | 1 | I/O line enable |
| phase_irq | output | 1 | Phase-mismatch interrupt pending |
| send_ok | output | 1 | Initiator may send outgoing data |
| undef_phase | output | 1 | Live phase is an undefined code |
| last_sent | output | 1 | Last DMA byte has reached the bus |

## Verification
The bench goes after the request bit in initiator role. A design that let it through would drive REQ as an initiator. It also checks that a REQ held high after an interrupt clear does not fire again; a level-triggered design would re-raise the interrupt at once. It checks that a mismatch with DMA off raises nothing. It checks that writing bit 7 or omitting the end-of-DMA mark leaves the last-byte flag clear, so a design that conflates the two marks would set the flag early. Undefined phase codes on the live lines are checked both with matching and with mismatching register values.

// File: rtl/scsi_phase_ctl.sv
module scsi_phase_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       tgt_mode,
  input  logic       dma_mode,
  input  logic       bus_req,
  input  logic       bus_msg,
  input  logic       bus_cd,
  input  logic       bus_io,
  input  logic       int_clr,
  input  logic       dma_start,
  input  logic       dma_last,
  input  logic       byte_sent,
  output logic       drv_req,
  output logic       drv_msg,
  output logic       drv_cd,
  output logic       drv_io,
  output logic       phase_irq,
  output logic       send_ok,
  output logic       undef_phase,
  output logic       last_sent
);

  logic [2:0] phase_q;
  logic       req_bit;
  logic       lbs_q;
  logic       fetched_last;
  logic [3:0] sync1, sync2;
  logic       req_prev;
  logic       unused_wr;

  assign unused_wr = ^wr_data[7:4];

  // register
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase_q <= 3'b000;
      req_bit <= 1'b0;
    end else if (wr_en) begin
      phase_q <= wr_data[2:0];
      req_bit <= wr_data[3];
    end

  assign rd_data = {lbs_q, 3'b000, req_bit, phase_q};

  assign drv_req = tgt_mode & req_bit;
  assign drv_msg = tgt_mode & phase_q[2];
  assign drv_cd  = tgt_mode & phase_q[1];
  assign drv_io  = tgt_mode & phase_q[0];

  // two-stage synchroniser: {req, msg, cd, io}
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1    <= '0;
      sync2    <= '0;
      req_prev <= 1'b0;
    end else begin
      sync1    <= {bus_req, bus_msg, bus_cd, bus_io};
      sync2    <= sync1;
      req_prev <= sync2[3];
    end

  logic [2:0] live_phase;
  logic       req_rise, mismatch_hit;
  assign live_phase   = sync2[2:0];
  assign req_rise     = sync2[3] & ~req_prev;
  assign mismatch_hit = req_rise & ~tgt_mode & dma_mode & (live_phase != phase_q);

  assign send_ok     = ~tgt_mode & (live_phase == phase_q);
  assign undef_phase = (live_phase[2:1] == 2'b10);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            phase_irq <= 1'b0;
    else if (mismatch_hit) phase_irq <= 1'b1;
    else if (int_clr)      phase_irq <= 1'b0;

  // last byte sent tracking
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lbs_q        <= 1'b0;
      fetched_last <= 1'b0;
    end else if (dma_start) begin
      lbs_q        <= 1'b0;
      fetched_last <= 1'b0;
    end else begin
      if (wr_en) lbs_q <= 1'b0;
      else if (byte_sent & fetched_last & ~tgt_mode & dma_mode) lbs_q <= 1'b1;
      if (dma_last) fetched_last <= 1'b1;
    end

  assign last_sent = lbs_q;

  p_tgt_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tgt_mode) |=> (!tgt_mode ||
      {drv_req, drv_msg, drv_cd, drv_io} == $past(wr_data[3:0])));

  p_init_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_mode |-> !(drv_req || drv_msg || drv_cd || drv_io));

  p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_irq) |-> $past(dma_mode && !tgt_mode));

  p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_irq && !int_clr) |=> phase_irq);

  p_lbs_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(last_sent) |-> $past(byte_sent));

  p_lbs_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || dma_start) |=> !last_sent);

endmodule

// File: tb/scsi_phase_ctl_test.sv
module scsi_phase_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {tgt, dma, wdata[3:0], live[2:0], drv{req,msg,cd,io}, send_ok, irq, undef}
  localparam logic [15:0] VEC [NVEC] = '{
    16'b1_0_1011_000_1011_0_0_0,
    16'b1_1_0110_110_0110_0_0_0,
    16'b0_1_1001_001_0000_1_0_0,
    16'b0_1_0010_011_0000_0_1_0,
    16'b0_0_0000_111_0000_0_0_0,
    16'b0_1_0111_100_0000_0_1_1,
    16'b0_0_1101_101_0000_1_0_1,
    16'b1_1_1111_010_1111_0_0_0
  };

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, tgt_mode = 0, dma_mode = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic bus_req = 0, bus_msg = 0, bus_cd = 0, bus_io = 0;
  logic int_clr = 0, dma_start = 0, dma_last = 0, byte_sent = 0;
  logic drv_req, drv_msg, drv_cd, drv_io, phase_irq, send_ok, undef_phase, last_sent;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_phase_ctl uut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(input logic [7:0] d);
    wr_en = 1; wr_data = d; cyc(1); wr_en = 0;
  endtask

  task automatic pulse_clr();
    int_clr = 1; cyc(1); int_clr = 0;
  endtask

  initial begin
    cyc(2);
    chk("R1 reset rd_data", rd_data, 8'h00);
    chk("R1 reset outputs", {drv_req, drv_msg, drv_cd, drv_io, phase_irq, send_ok, undef_phase, last_sent}, 8'b0000_0100);
    rst_n = 1;
    cyc(1);

    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] v;
      v = VEC[i];
      pulse_clr();
      tgt_mode = v[15]; dma_mode = v[14];
      write({4'b0000, v[13:10]});
      chk("R2 R3 drive after write", {4'b0, drv_req, drv_msg, drv_cd, drv_io}, {4'b0, v[6:3]});
      chk("R1 readback", rd_data, {4'b0000, v[13:10]});
      {bus_msg, bus_cd, bus_io} = v[9:7]; bus_req = 0;
      cyc(3);
      bus_req = 1;
      cyc(3);
      chk("R6 send_ok", {7'b0, send_ok}, {7'b0, v[2]});
      chk("R4 phase_irq", {7'b0, phase_irq}, {7'b0, v[1]});
      chk("R7 undef_phase", {7'b0, undef_phase}, {7'b0, v[0]});
      chk("R2 R3 drive", {4'b0, drv_req, drv_msg, drv_cd, drv_io}, {4'b0, v[6:3]});
      bus_req = 0;
      cyc(3);
    end

    // R5: pending until cleared, no re-trigger on held REQ
    tgt_mode = 0; dma_mode = 1; pulse_clr();
    write(8'h02);
    {bus_msg, bus_cd, bus_io} = 3'b011; cyc(3);
    bus_req = 1; cyc(3);
    chk("R5 irq set", {7'b0, phase_irq}, 8'd1);
    bus_req = 0; cyc(5);
    chk("R5 irq held after REQ drop", {7'b0, phase_irq}, 8'd1);
    bus_req = 1; cyc(3);
    pulse_clr(); cyc(4);
    chk("R5 no retrigger on held REQ", {7'b0, phase_irq}, 8'd0);
    // R4 latency: two edges after REQ rises at the pins, not yet set
    bus_req = 0; cyc(3);
    bus_req = 1; cyc(2);
    chk("R4 not yet at second edge", {7'b0, phase_irq}, 8'd0);
    cyc(1);
    chk("R4 set at third edge", {7'b0, phase_irq}, 8'd1);
    bus_req = 0; pulse_clr(); cyc(2);

    // R9: writing bit 7 and reserved bits does not set them
    write(8'hF5);
    chk("R9 R1 write bit7/reserved", rd_data, 8'h05);
    chk("R9 last_sent after write", {7'b0, last_sent}, 8'd0);

    // R8: byte_sent without dma_last
    byte_sent = 1; cyc(1); byte_sent = 0;
    chk("R8 no set without dma_last", {7'b0, last_sent}, 8'd0);
    dma_last = 1; cyc(1); dma_last = 0;
    chk("R8 dma_last alone", {7'b0, last_sent}, 8'd0);
    byte_sent = 1; cyc(1); byte_sent = 0;
    chk("R8 set after last byte sent", {7'b0, last_sent}, 8'd1);
    chk("R1 R8 bit7 readback", rd_data, 8'h85);
    write(8'h05);
    chk("R9 cleared by write", {7'b0, last_sent}, 8'd0);
    byte_sent = 1; cyc(1); byte_sent = 0;
    chk("R8 re-set by later byte", {7'b0, last_sent}, 8'd1);
    dma_start = 1; cyc(1); dma_start = 0;
    chk("R9 cleared by dma_start", {7'b0, last_sent}, 8'd0);
    byte_sent = 1; cyc(1); byte_sent = 0;
    chk("R9 dma_start forgets dma_last", {7'b0, last_sent}, 8'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule